// File: doc/BRIEF.md
# Debug Command Sequencer Engine

This block sits between a host debug serial link and on-chip firmware. The link delivers whole bytes, each marked by a one-cycle valid strobe. The engine decodes each opcode byte and gathers the operand bytes that follow it, low byte first, into a 16-bit address register and a 16-bit data register. It then passes the task to firmware: it writes a 4-bit command code and pulses a request to jump to a fixed service vector. Some commands need no operands and make this request straight away.

For its side of the exchange, firmware sees three things: an 8-bit byte buffer, a transmit-complete flag (TXC) and a task-done flag (ROD). Firmware sets TXC once it has loaded the buffer. The engine then requests a shift toward the host and clears TXC when the shift is done. Firmware sets ROD when a task is finished. The engine clears ROD and becomes ready for the next opcode.

The engine also controls the CPU run/halt line. A halt request takes the block from background mode into debug mode. The trace command releases the CPU for one cycle only. The return command goes back to background mode with the CPU running.

Top module: `dbg_cmd_engine`

## Requirements
- R1: After reset the engine is in background mode (`debug_mode`=0, `cpu_run`=1), with `cmd_code`=0, `txc`=0, `rod`=0 and `jump_req`=0.
- R2: In background mode, host bytes are ignored. A `halt_req` pulse makes `debug_mode`=1 and `cpu_run`=0 from the next cycle, and the engine becomes ready for opcodes. Whenever `debug_mode` is 1, `cpu_run` is 0.
- R3: For opcodes 0x22, 0x23, 0x24 and 0x25, the next four host bytes are taken in this order: address low, address high, data low, data high. In the cycle after the fourth byte, `addr_reg` and `data_reg` hold the new values, `cmd_code` equals the opcode's low nibble, and `jump_req` is high for exactly one cycle.
- R4: Opcode 0x29 takes two host bytes, address low then address high, into `addr_reg`. It leaves `data_reg` unchanged, then sets `cmd_code`=9 and pulses `jump_req`.
- R5: Opcodes 0x21 and 0x28 set `cmd_code` to 1 and 8 respectively, and pulse `jump_req`, in the cycle after the opcode byte, without waiting for operands.
- R6: After opcode 0x28, each of the next 32 host bytes is written to `buf_byte` in the cycle after it arrives. Once the 32nd byte has arrived, the engine waits for ROD.
- R7: Opcode 0x26 drives `cpu_run`=1 and `debug_mode`=0 for exactly one cycle. The engine then returns to debug mode, ready for opcodes, with no jump request.
- R8: Opcode 0x27 returns the engine to background mode (`debug_mode`=0, `cpu_run`=1). `cpu_run` or `debug_mode` is always 1.
- R9: Opcode 0x20, and any byte outside 0x20 to 0x29, changes none of `cmd_code`, `addr_reg`, `data_reg` or `buf_byte`, raises no jump, and leaves the engine ready.
- R10: A `fw_txc_set` pulse sets `txc`, and `shift_req` follows `txc` with `buf_byte` as the byte to send. A `shift_done` pulse while `txc` is 1 clears `txc` in the next cycle. A firmware buffer write loads `buf_byte`.
- R11: A `fw_rod_set` pulse sets `rod`. While a task is pending, the engine clears `rod` one cycle after it becomes 1 and returns to ready.
- R12: Host bytes that arrive while a task is pending (between the jump request and ROD being seen) are ignored: no jump, and no change to `cmd_code`, `addr_reg` or `data_reg`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_req | input | 1 | Break request; enters debug mode from background |
| host_vld | input | 1 | Host byte strobe |
| host_byte | input | 8 | Host byte (opcode or operand) |
| shift_req | output | 1 | Request to shift `buf_byte` out to the host |
| shift_done | input | 1 | Shifter finished sending the byte |
| fw_buf_we | input | 1 | Firmware write strobe for the byte buffer |
| fw_buf_wdata | input | 8 | Firmware byte for the buffer |
| fw_txc_set | input | 1 | Firmware sets TXC |
| fw_rod_set | input | 1 | Firmware sets ROD |
| cmd_code | output | 4 | Command code for firmware |
| addr_reg | output | 16 | Gathered address operand |
| data_reg | output | 16 | Gathered second operand |
| buf_byte | output | 8 | Byte buffer |
| txc | output | 1 | Transmit-complete flag |
| rod | output | 1 | Task-done flag |
| jump_req | output | 1 | One-cycle request to jump to the service vector |
| jump_vec | output | 16 | Service vector address (0x8010) |
| cpu_run | output | 1 | CPU run enable |
| debug_mode | output | 1 | Debug mode indicator |

## Verification
The assertions assume three things about the inputs. Firmware does not write the byte buffer while the engine is loading password bytes into it. `shift_done` is pulsed only while a shift is requested. `halt_req` is used only as a break request. The stimulus keeps to these assumptions. Each input is driven for one cycle at a time, half a cycle after the active edge. The firmware pulses follow the handshake order (load, set TXC, wait, shift done; then ROD after the task is issued). The ROD pulse is sometimes sent early, while operands are still arriving, to check that the flag is held until the engine is waiting for it.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;

    // Engine sequencing states
    typedef enum logic [2:0] {
        ST_BKG   = 3'd0,   // background: CPU runs, host bytes ignored
        ST_READY = 3'd1,   // debug mode, waiting for an opcode
        ST_OPND  = 3'd2,   // gathering address/data operand bytes
        ST_PWD   = 3'd3,   // streaming password bytes into the buffer
        ST_BUSY  = 3'd4,   // firmware task pending, waiting for ROD
        ST_STEP  = 3'd5    // one-cycle CPU release for trace
    } eng_st_e;

    // Opcode classes produced by the decoder
    typedef enum logic [2:0] {
        K_NOP     = 3'd0,
        K_HANDOFF = 3'd1,  // immediate firmware handoff
        K_GATHER  = 3'd2,  // collect operands, then handoff
        K_PWD     = 3'd3,  // handoff, then stream bytes to buffer
        K_STEP    = 3'd4,
        K_RET     = 3'd5
    } op_kind_e;

    localparam logic [3:0] OP_GROUP = 4'h2;

endpackage

// File: rtl/dbg_op_decode.sv
module dbg_op_decode
    import dbg_cmd_pkg::*;
#(
    parameter int PWD_BYTES = 32,
    parameter int CW        = $clog2(PWD_BYTES + 1)
) (
    input  logic [7:0]    op_i,
    output op_kind_e      kind_o,
    output logic [3:0]    nib_o,
    output logic [CW-1:0] nopnd_o
);

    localparam int WIDE_OPS  = 4;   // address word + data word
    localparam int NARROW_OPS = 2;  // address word only

    always_comb begin
        kind_o  = K_NOP;
        nib_o   = op_i[3:0];
        nopnd_o = '0;
        if (op_i[7:4] == OP_GROUP) begin
            unique case (op_i[3:0])
                4'h1: kind_o = K_HANDOFF;
                4'h2, 4'h3, 4'h4, 4'h5: begin
                    kind_o  = K_GATHER;
                    nopnd_o = CW'(WIDE_OPS);
                end
                4'h6: kind_o = K_STEP;
                4'h7: kind_o = K_RET;
                4'h8: begin
                    kind_o  = K_PWD;
                    nopnd_o = CW'(PWD_BYTES);
                end
                4'h9: begin
                    kind_o  = K_GATHER;
                    nopnd_o = CW'(NARROW_OPS);
                end
                default: kind_o = K_NOP;
            endcase
        end
    end

endmodule

// File: rtl/dbg_opnd_gather.sv
module dbg_opnd_gather #(
    parameter int WORD_W = 16,
    parameter int CW     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              load_cap_i,
    input  logic [CW-1:0]     load_cnt_i,
    input  logic              byte_vld_i,
    input  logic [7:0]        byte_i,
    output logic [WORD_W-1:0] addr_o,
    output logic [WORD_W-1:0] data_o,
    output logic              last_o
);

    localparam int LANES = WORD_W / 8;

    typedef struct packed {
        logic [CW-1:0]     rem;
        logic [CW-1:0]     idx;
        logic              cap;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } gath_t;

    gath_t g_d, g_q;

    always_comb begin
        g_d    = g_q;
        last_o = 1'b0;
        if (load_i) begin
            g_d.rem = load_cnt_i;
            g_d.idx = '0;
            g_d.cap = load_cap_i;
        end else if (byte_vld_i && (g_q.rem != '0)) begin
            g_d.rem = g_q.rem - 1'b1;
            g_d.idx = g_q.idx + 1'b1;
            last_o  = (g_q.rem == CW'(1));
            if (g_q.cap) begin
                for (int lane = 0; lane < LANES; lane++) begin
                    if (g_q.idx == CW'(lane))
                        g_d.addr[lane*8 +: 8] = byte_i;
                    if (g_q.idx == CW'(LANES + lane))
                        g_d.data[lane*8 +: 8] = byte_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign addr_o = g_q.addr;
    assign data_o = g_q.data;

endmodule

// File: rtl/dbg_tx_hs.sv
module dbg_tx_hs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       eng_we_i,
    input  logic [7:0] eng_byte_i,
    input  logic       fw_we_i,
    input  logic [7:0] fw_byte_i,
    input  logic       txc_set_i,
    input  logic       shift_done_i,
    output logic [7:0] buf_o,
    output logic       txc_o
);

    typedef struct packed {
        logic [7:0] bytebuf;
        logic       txc;
    } tx_t;

    tx_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (eng_we_i)      t_d.bytebuf = eng_byte_i;
        else if (fw_we_i)  t_d.bytebuf = fw_byte_i;
        if (t_q.txc && shift_done_i) t_d.txc = 1'b0;
        else if (txc_set_i)          t_d.txc = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign buf_o = t_q.bytebuf;
    assign txc_o = t_q.txc;

endmodule

// File: rtl/dbg_cmd_engine.sv
module dbg_cmd_engine
    import dbg_cmd_pkg::*;
#(
    parameter int          WORD_W    = 16,
    parameter int          PWD_BYTES = 32,
    parameter logic [15:0] VEC_ADDR  = 16'h8010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_req,
    input  logic              host_vld,
    input  logic [7:0]        host_byte,
    output logic              shift_req,
    input  logic              shift_done,
    input  logic              fw_buf_we,
    input  logic [7:0]        fw_buf_wdata,
    input  logic              fw_txc_set,
    input  logic              fw_rod_set,
    output logic [3:0]        cmd_code,
    output logic [WORD_W-1:0] addr_reg,
    output logic [WORD_W-1:0] data_reg,
    output logic [7:0]        buf_byte,
    output logic              txc,
    output logic              rod,
    output logic              jump_req,
    output logic [15:0]       jump_vec,
    output logic              cpu_run,
    output logic              debug_mode
);

    localparam int CW = $clog2(PWD_BYTES + 1);

    typedef struct packed {
        eng_st_e    st;
        logic [3:0] cmd;
        logic [3:0] pend;
        logic       jump;
        logic       run;
        logic       dbg;
        logic       rod;
    } eng_t;

    eng_t e_d, e_q;

    op_kind_e      dec_kind;
    logic [3:0]    dec_nib;
    logic [CW-1:0] dec_nopnd;

    logic          g_load, g_cap, g_vld, g_last;
    logic          eng_buf_we;

    dbg_op_decode #(.PWD_BYTES(PWD_BYTES), .CW(CW)) u_dec (
        .op_i    (host_byte),
        .kind_o  (dec_kind),
        .nib_o   (dec_nib),
        .nopnd_o (dec_nopnd)
    );

    assign g_vld = host_vld && ((e_q.st == ST_OPND) || (e_q.st == ST_PWD));

    dbg_opnd_gather #(.WORD_W(WORD_W), .CW(CW)) u_gather (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (g_load),
        .load_cap_i (g_cap),
        .load_cnt_i (dec_nopnd),
        .byte_vld_i (g_vld),
        .byte_i     (host_byte),
        .addr_o     (addr_reg),
        .data_o     (data_reg),
        .last_o     (g_last)
    );

    dbg_tx_hs u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .eng_we_i     (eng_buf_we),
        .eng_byte_i   (host_byte),
        .fw_we_i      (fw_buf_we),
        .fw_byte_i    (fw_buf_wdata),
        .txc_set_i    (fw_txc_set),
        .shift_done_i (shift_done),
        .buf_o        (buf_byte),
        .txc_o        (txc)
    );

    always_comb begin
        e_d        = e_q;
        e_d.jump   = 1'b0;
        g_load     = 1'b0;
        g_cap      = 1'b0;
        eng_buf_we = 1'b0;
        if (fw_rod_set) e_d.rod = 1'b1;

        unique case (e_q.st)
            ST_BKG: begin
                if (halt_req) begin
                    e_d.st  = ST_READY;
                    e_d.run = 1'b0;
                    e_d.dbg = 1'b1;
                end
            end
            ST_READY: begin
                if (host_vld) begin
                    unique case (dec_kind)
                        K_HANDOFF: begin
                            e_d.cmd  = dec_nib;
                            e_d.jump = 1'b1;
                            e_d.st   = ST_BUSY;
                        end
                        K_GATHER: begin
                            g_load   = 1'b1;
                            g_cap    = 1'b1;
                            e_d.pend = dec_nib;
                            e_d.st   = ST_OPND;
                        end
                        K_PWD: begin
                            g_load   = 1'b1;
                            e_d.cmd  = dec_nib;
                            e_d.jump = 1'b1;
                            e_d.st   = ST_PWD;
                        end
                        K_STEP: begin
                            e_d.run = 1'b1;
                            e_d.dbg = 1'b0;
                            e_d.st  = ST_STEP;
                        end
                        K_RET: begin
                            e_d.run = 1'b1;
                            e_d.dbg = 1'b0;
                            e_d.st  = ST_BKG;
                        end
                        default: ;
                    endcase
                end
            end
            ST_OPND: begin
                if (g_last) begin
                    e_d.cmd  = e_q.pend;
                    e_d.jump = 1'b1;
                    e_d.st   = ST_BUSY;
                end
            end
            ST_PWD: begin
                eng_buf_we = host_vld;
                if (g_last) e_d.st = ST_BUSY;
            end
            ST_BUSY: begin
                if (e_q.rod) begin
                    e_d.rod = 1'b0;
                    e_d.st  = ST_READY;
                end
            end
            ST_STEP: begin
                e_d.run = 1'b0;
                e_d.dbg = 1'b1;
                e_d.st  = ST_READY;
            end
            default: e_d.st = ST_BKG;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q      <= '0;
            e_q.st   <= ST_BKG;
            e_q.run  <= 1'b1;
        end else begin
            e_q <= e_d;
        end
    end

    assign cmd_code   = e_q.cmd;
    assign jump_req   = e_q.jump;
    assign jump_vec   = VEC_ADDR;
    assign cpu_run    = e_q.run;
    assign debug_mode = e_q.dbg;
    assign rod        = e_q.rod;
    assign shift_req  = txc;

endmodule

// File: rtl/dbg_cmd_engine_chk.sv
module dbg_cmd_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_vld,
    input logic        shift_done,
    input logic [3:0]  cmd_code,
    input logic [15:0] addr_reg,
    input logic        txc,
    input logic        jump_req,
    input logic        cpu_run,
    input logic        debug_mode
);

    // R2: the CPU is halted whenever debug mode is active
    a_r2_halted_in_debug: assert property (@(posedge clk) disable iff (!rst_n)
        debug_mode |-> !cpu_run);

    // R8: never both halted and outside debug mode
    a_r8_run_or_debug: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_run || debug_mode);

    // R3: the jump request lasts one cycle
    a_r3_jump_single: assert property (@(posedge clk) disable iff (!rst_n)
        jump_req |=> !jump_req);

    // R5: a jump request only follows a host byte, inside debug mode
    a_r5_jump_from_host: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jump_req) |-> ($past(host_vld) && debug_mode));

    // R9: the command code changes only together with a jump request
    a_r9_cmd_with_jump: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_code) |-> jump_req);

    // R4: the address register moves only on a received host byte
    a_r4_addr_from_host: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(addr_reg) |-> $past(host_vld));

    // R10: a completed shift clears the transmit flag
    a_r10_txc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (txc && shift_done) |=> !txc);

endmodule

bind dbg_cmd_engine dbg_cmd_engine_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_vld   (host_vld),
    .shift_done (shift_done),
    .cmd_code   (cmd_code),
    .addr_reg   (addr_reg),
    .txc        (txc),
    .jump_req   (jump_req),
    .cpu_run    (cpu_run),
    .debug_mode (debug_mode)
);

// File: tb/dbg_cmd_engine_tb.sv
module dbg_cmd_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        halt_req = 1'b0;
    logic        host_vld = 1'b0;
    logic [7:0]  host_byte = 8'h00;
    logic        shift_done = 1'b0;
    logic        fw_buf_we = 1'b0;
    logic [7:0]  fw_buf_wdata = 8'h00;
    logic        fw_txc_set = 1'b0;
    logic        fw_rod_set = 1'b0;
    logic        shift_req, txc, rod, jump_req, cpu_run, debug_mode;
    logic [3:0]  cmd_code;
    logic [15:0] addr_reg, data_reg, jump_vec;
    logic [7:0]  buf_byte;

    always #2 clk = ~clk;   // 250 MHz

    dbg_cmd_engine u_dut (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req),
        .host_vld(host_vld), .host_byte(host_byte),
        .shift_req(shift_req), .shift_done(shift_done),
        .fw_buf_we(fw_buf_we), .fw_buf_wdata(fw_buf_wdata),
        .fw_txc_set(fw_txc_set), .fw_rod_set(fw_rod_set),
        .cmd_code(cmd_code), .addr_reg(addr_reg), .data_reg(data_reg),
        .buf_byte(buf_byte), .txc(txc), .rod(rod), .jump_req(jump_req),
        .jump_vec(jump_vec), .cpu_run(cpu_run), .debug_mode(debug_mode)
    );

    int    vectors = 0;
    int    miscompares = 0;
    int    cycles = 0;
    bit    started = 0;
    bit    finished = 0;
    string req = "R1";

    // ---------------- behavioural reference model ----------------
    // mode: "bkg", "ready", "operand", "password", "pending", "step"
    string       m_mode = "bkg";
    int          m_left = 0;
    int          m_count = 0;
    int          m_op = 0;
    bit          m_run = 1, m_dbg = 0, m_txc = 0, m_rod = 0, m_jump = 0;
    int          m_cmd = 0, m_addr = 0, m_data = 0, m_buf = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = "bkg"; m_left = 0; m_count = 0; m_op = 0;
            m_run = 1; m_dbg = 0; m_txc = 0; m_rod = 0; m_jump = 0;
            m_cmd = 0; m_addr = 0; m_data = 0; m_buf = 0;
        end else begin
            bit old_rod;
            old_rod = m_rod;
            m_jump = 0;
            if (fw_buf_we) m_buf = fw_buf_wdata;
            if (m_txc && shift_done) m_txc = 0;
            else if (fw_txc_set)     m_txc = 1;
            if (fw_rod_set) m_rod = 1;
            if (m_mode == "bkg") begin
                if (halt_req) begin m_mode = "ready"; m_run = 0; m_dbg = 1; end
            end else if (m_mode == "ready") begin
                if (host_vld) begin
                    m_op = host_byte;
                    if (host_byte == 8'h21) begin
                        m_cmd = 1; m_jump = 1; m_mode = "pending";
                    end else if (host_byte >= 8'h22 && host_byte <= 8'h25) begin
                        m_left = 4; m_count = 0; m_mode = "operand";
                    end else if (host_byte == 8'h29) begin
                        m_left = 2; m_count = 0; m_mode = "operand";
                    end else if (host_byte == 8'h28) begin
                        m_cmd = 8; m_jump = 1; m_left = 32; m_mode = "password";
                    end else if (host_byte == 8'h26) begin
                        m_run = 1; m_dbg = 0; m_mode = "step";
                    end else if (host_byte == 8'h27) begin
                        m_run = 1; m_dbg = 0; m_mode = "bkg";
                    end
                end
            end else if (m_mode == "operand") begin
                if (host_vld) begin
                    case (m_count)
                        0: m_addr = (m_addr & 16'hFF00) | host_byte;
                        1: m_addr = (m_addr & 16'h00FF) | (host_byte << 8);
                        2: m_data = (m_data & 16'hFF00) | host_byte;
                        default: m_data = (m_data & 16'h00FF) | (host_byte << 8);
                    endcase
                    m_count++; m_left--;
                    if (m_left == 0) begin
                        m_cmd = m_op & 15; m_jump = 1; m_mode = "pending";
                    end
                end
            end else if (m_mode == "password") begin
                if (host_vld) begin
                    m_buf = host_byte; m_left--;
                    if (m_left == 0) m_mode = "pending";
                end
            end else if (m_mode == "pending") begin
                if (old_rod) begin m_rod = 0; m_mode = "ready"; end
            end else if (m_mode == "step") begin
                m_run = 0; m_dbg = 1; m_mode = "ready";
            end
            started = 1;
        end
    end

    // ---------------- comparison, away from the active edge ----------------
    task automatic cmp(string name, int act, int exp);
        if (act != exp) begin
            $display("FAIL %s %s: actual=%0h expected=%0h at t=%0t", req, name, act, exp, $time);
            miscompares++;
        end
    endtask

    always @(negedge clk) begin
        if (started && !finished) begin
            vectors++;
            cmp("debug_mode", int'(debug_mode), int'(m_dbg));
            cmp("cpu_run", int'(cpu_run), int'(m_run));
            cmp("cmd_code", int'(cmd_code), m_cmd);
            cmp("jump_req", int'(jump_req), int'(m_jump));
            cmp("addr_reg", int'(addr_reg), m_addr);
            cmp("data_reg", int'(data_reg), m_data);
            cmp("buf_byte", int'(buf_byte), m_buf);
            cmp("txc", int'(txc), int'(m_txc));
            cmp("shift_req", int'(shift_req), int'(m_txc));
            cmp("rod", int'(rod), int'(m_rod));
            cmp("jump_vec", int'(jump_vec), 16'h8010);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic send(logic [7:0] b);
        @(negedge clk); #1; host_vld = 1; host_byte = b;
        @(negedge clk); #1; host_vld = 0;
    endtask

    task automatic send_burst(logic [7:0] b);   // no gap after the byte
        @(negedge clk); #1; host_vld = 1; host_byte = b;
    endtask

    task automatic halt();
        @(negedge clk); #1; halt_req = 1;
        @(negedge clk); #1; halt_req = 0;
    endtask

    task automatic rod_pulse();
        @(negedge clk); #1; fw_rod_set = 1;
        @(negedge clk); #1; fw_rod_set = 0;
    endtask

    task automatic fw_send(logic [7:0] b, int wait_cycles);
        @(negedge clk); #1; fw_buf_we = 1; fw_buf_wdata = b;
        @(negedge clk); #1; fw_buf_we = 0; fw_txc_set = 1;
        @(negedge clk); #1; fw_txc_set = 0;
        tick(wait_cycles);
        @(negedge clk); #1; shift_done = 1;
        @(negedge clk); #1; shift_done = 0;
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL %s watchdog: actual=%0d cycles expected=done", req, cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // ---------------- test sequence ----------------
    initial begin
        req = "R1";
        tick(3);
        rst_n = 1;
        tick(3);

        req = "R2";                        // bytes ignored in background
        send(8'h21); send(8'h22); send(8'h28);
        halt();
        tick(2);

        req = "R9";                        // no-op and out-of-range bytes
        send(8'h20); send(8'h2A); send(8'h55); send(8'hFF); send(8'h1F); send(8'h30);
        tick(2);

        req = "R3";                        // four-operand commands
        for (int op = 8'h22; op <= 8'h25; op++) begin
            send(8'(op));
            send(8'(op * 3)); send(8'(op + 8'h40)); send(8'(op ^ 8'hA5)); send(8'(8'hF0 - op));
            req = "R11";
            rod_pulse();
            tick(1);
            req = "R3";
        end
        send_burst(8'h24); send_burst(8'h11); send_burst(8'h22);
        send_burst(8'h33); send_burst(8'h44);
        @(negedge clk); #1; host_vld = 0;

        req = "R12";                       // bytes while pending are ignored
        send(8'h21); send(8'h22); send(8'h99); send(8'h28);
        tick(2);
        req = "R11";
        rod_pulse();
        tick(2);

        req = "R4";                        // two-operand register read
        send(8'h29); send(8'hCD);
        req = "R11";
        rod_pulse();                       // early ROD must be held
        req = "R4";
        send(8'hAB);
        tick(3);

        req = "R5";                        // immediate handoff + TXC traffic
        send(8'h21);
        req = "R10";
        fw_send(8'hA5, 2);
        fw_send(8'h3C, 0);
        fw_send(8'h00, 5);
        req = "R11";
        rod_pulse();
        tick(2);

        req = "R6";                        // password stream
        send(8'h28);
        for (int k = 0; k < 32; k++) begin
            if (k % 5 == 0) send(8'(k * 7 + 1));
            else            send_burst(8'(k * 7 + 1));
        end
        @(negedge clk); #1; host_vld = 0;
        req = "R12";
        send(8'h77); send(8'h22);
        req = "R11";
        rod_pulse();
        tick(2);

        req = "R7";                        // single step
        send(8'h26);
        tick(2);
        send_burst(8'h26); send_burst(8'h20);
        @(negedge clk); #1; host_vld = 0;
        tick(2);

        req = "R8";                        // return to background
        send(8'h27);
        req = "R2";
        send(8'h21);
        tick(3);
        halt();
        req = "R8";
        send(8'h27);
        tick(3);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule